// File: doc/BRIEF.md
# Address-Triggered Operand Register Unit

This unit holds three register files: eight 18-bit address registers, eight 18-bit index registers and eight 60-bit operand registers. It has one write port, one combinational read port for each file, and a single-request memory interface. Nothing in the design issues an explicit load or store. Instead, writing an address register can start a memory access as a side effect. The register number decides which kind of access, if any, takes place.

An address written into registers 1 to 5 starts a read. The returned word lands in the operand register with the same number. An address written into register 6 or 7 starts a write of the operand register with the same number. That operand value is captured at the moment the address register is written. Address register 0 is a scratch register and never touches memory.

Only one transfer can be in flight at a time. While a transfer waits for its acknowledge, `busy` is high and every write presented on the write port is refused. The caller keeps the write on the port until `busy` falls.

Top module: `opRegUnit`

## Requirements
- R1: After reset, every address, index and operand register reads zero, and `memReq` and `busy` are low.
- R2: A write to address register 0 updates that register and raises no memory request.
- R3: A write accepted into address register 1 to 5 gives, one cycle later, `memReq`=1, `memWe`=0, `busy`=1 and `memAddr` equal to the written address.
- R4: When `memAck` is sampled high during a load, `memRdata` is in the matching operand register and `busy` is low one cycle later.
- R5: A write accepted into address register 6 or 7 gives, one cycle later, `memReq`=1, `memWe`=1, the written address on `memAddr`, and on `memWdata` the operand register of the same number as it was when the write was accepted.
- R6: While a request is pending without acknowledge, `memReq`, `memWe`, `memAddr` and `memWdata` hold their values.
- R7: A write presented while `busy` is high changes no register. It is taken only in a later cycle in which `busy` is low.
- R8: Index register 0 always reads zero and ignores writes. Index registers 1 to 7 read back the low 18 bits written to them.
- R9: Operand registers accept direct 60-bit writes. A later load into the same register overwrites the directly written value.
- R10: `wrFile` selects the target file: 0 address, 1 index, 2 operand, 3 none. A write with code 3 changes no register and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write request |
| wrFile | input | 2 | File select (0 addr, 1 index, 2 operand, 3 none) |
| wrIdx | input | 3 | Register number |
| wrData | input | 60 | Write data (low 18 bits for address/index) |
| busy | output | 1 | Transfer pending; writes are refused |
| rdAddrIdx | input | 3 | Address file read select |
| rdAddrData | output | 18 | Address file read data |
| rdIndexIdx | input | 3 | Index file read select |
| rdIndexData | output | 18 | Index file read data |
| rdOperIdx | input | 3 | Operand file read select |
| rdOperData | output | 60 | Operand file read data |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 for a store, 0 for a load |
| memAddr | output | 18 | Memory address |
| memWdata | output | 60 | Store data |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | 60 | Load data, valid with `memAck` |

## Verification
A load completion and a new write request can arrive in the same cycle. The write is still refused, because `busy` stays high through the acknowledge cycle. The bench provokes this by holding a write to an index register on the port while it raises `memAck` for a pending load. It then checks three things: the loaded word reached the operand register, the index register was still unchanged one cycle later, and the held write took effect in the next cycle.

// File: rtl/oru_pkg.sv
package oru_pkg;
  localparam int ADDR_W   = 18;
  localparam int DATA_W   = 60;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int LOAD_LO  = 1;
  localparam int LOAD_HI  = 5;

  typedef enum logic [1:0] {
    FILE_ADDR  = 2'd0,
    FILE_INDEX = 2'd1,
    FILE_OPER  = 2'd2,
    FILE_NONE  = 2'd3
  } regFile_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_STORE = 2'd2
  } xferState_e;

  typedef struct packed {
    logic addrWe;
    logic indexWe;
    logic operWe;
    logic launch;
    logic launchStore;
    logic loadDone;
  } ctrlStrobes_t;
endpackage

// File: rtl/oru_ctrl.sv
module oru_ctrl
  import oru_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrFile,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               memAck,
  output ctrlStrobes_t       strobes,
  output logic               busy,
  output logic               memReq,
  output logic               memWe
);
  xferState_e state, stateNext;
  logic accept;
  logic isLoadIdx;
  logic isStoreIdx;

  assign accept     = wrEn && (state == ST_IDLE);
  assign isLoadIdx  = (int'(wrIdx) >= LOAD_LO) && (int'(wrIdx) <= LOAD_HI);
  assign isStoreIdx = int'(wrIdx) > LOAD_HI;

  always_comb begin
    strobes             = '0;
    strobes.addrWe      = accept && (wrFile == FILE_ADDR);
    strobes.indexWe     = accept && (wrFile == FILE_INDEX);
    strobes.operWe      = accept && (wrFile == FILE_OPER);
    strobes.launch      = strobes.addrWe && (isLoadIdx || isStoreIdx);
    strobes.launchStore = strobes.addrWe && isStoreIdx;
    strobes.loadDone    = (state == ST_LOAD) && memAck;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (strobes.launchStore)  stateNext = ST_STORE;
        else if (strobes.launch)  stateNext = ST_LOAD;
      end
      ST_LOAD, ST_STORE: begin
        if (memAck) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = busy;
  assign memWe  = (state == ST_STORE);

  AST_SCRATCH_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && wrFile == FILE_ADDR && wrIdx == '0) |=> !memReq) else $error("AST_SCRATCH_NO_REQ"); // R2
  AST_LOAD_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && wrFile == FILE_ADDR && isLoadIdx) |=> (memReq && !memWe)) else $error("AST_LOAD_LAUNCH"); // R3
  AST_STORE_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && wrFile == FILE_ADDR && isStoreIdx) |=> (memReq && memWe)) else $error("AST_STORE_LAUNCH"); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe))) else $error("AST_REQ_HOLD"); // R6
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> !busy) else $error("AST_ACK_RELEASE"); // R4
  AST_NONE_FILE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && wrFile == FILE_NONE) |=> !memReq) else $error("AST_NONE_FILE"); // R10
endmodule

// File: rtl/oru_datapath.sv
module oru_datapath
  import oru_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                busy,
  input  logic                memAck,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [IDX_W-1:0]    rdAddrIdx,
  input  logic [IDX_W-1:0]    rdIndexIdx,
  input  logic [IDX_W-1:0]    rdOperIdx,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   rdAddrData,
  output logic [ADDR_W-1:0]   rdIndexData,
  output logic [DATA_W-1:0]   rdOperData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata
);
  logic [ADDR_W-1:0] addrRegs  [NUM_REGS];
  logic [ADDR_W-1:0] indexRegs [NUM_REGS];
  logic [DATA_W-1:0] operRegs  [NUM_REGS];
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqData;
  logic [IDX_W-1:0]  reqDest;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        addrRegs[r]  <= '0;
        indexRegs[r] <= '0;
        operRegs[r]  <= '0;
      end
      reqAddr <= '0;
      reqData <= '0;
      reqDest <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strobes.addrWe && wrIdx == IDX_W'(r))
          addrRegs[r] <= wrData[ADDR_W-1:0];
        if (strobes.indexWe && wrIdx == IDX_W'(r) && r != 0)
          indexRegs[r] <= wrData[ADDR_W-1:0];
        if (strobes.operWe && wrIdx == IDX_W'(r))
          operRegs[r] <= wrData;
        else if (strobes.loadDone && reqDest == IDX_W'(r))
          operRegs[r] <= memRdata;
      end
      if (strobes.launch) begin
        reqAddr <= wrData[ADDR_W-1:0];
        reqData <= operRegs[wrIdx];
        reqDest <= wrIdx;
      end
    end
  end

  assign rdAddrData  = addrRegs[rdAddrIdx];
  assign rdIndexData = indexRegs[rdIndexIdx];
  assign rdOperData  = operRegs[rdOperIdx];
  assign memAddr     = reqAddr;
  assign memWdata    = reqData;

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memAck) |=> ($stable(memAddr) && $stable(memWdata))) else $error("AST_REQ_STABLE"); // R6
  AST_INDEX0_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdIndexIdx == '0) |-> (rdIndexData == '0)) else $error("AST_INDEX0_ZERO"); // R8

  for (genvar g = 0; g < NUM_REGS; g++) begin : gAst
    AST_STALL_ADDR: assert property (@(posedge clk) disable iff (!rstN)
      busy |=> $stable(addrRegs[g])) else $error("AST_STALL_ADDR"); // R7
    AST_STALL_INDEX: assert property (@(posedge clk) disable iff (!rstN)
      busy |=> $stable(indexRegs[g])) else $error("AST_STALL_INDEX"); // R7
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.loadDone && reqDest == IDX_W'(g)) |=> (operRegs[g] == $past(memRdata))) else $error("AST_LOAD_LANDS"); // R4
  end
endmodule

// File: rtl/opRegUnit.sv
module opRegUnit
  import oru_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrFile,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic                busy,
  input  logic [IDX_W-1:0]    rdAddrIdx,
  output logic [ADDR_W-1:0]   rdAddrData,
  input  logic [IDX_W-1:0]    rdIndexIdx,
  output logic [ADDR_W-1:0]   rdIndexData,
  input  logic [IDX_W-1:0]    rdOperIdx,
  output logic [DATA_W-1:0]   rdOperData,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic                memAck,
  input  logic [DATA_W-1:0]   memRdata
);
  ctrlStrobes_t strobes;

  oru_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrFile  (wrFile),
    .wrIdx   (wrIdx),
    .memAck  (memAck),
    .strobes (strobes),
    .busy    (busy),
    .memReq  (memReq),
    .memWe   (memWe)
  );

  oru_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .busy        (busy),
    .memAck      (memAck),
    .wrIdx       (wrIdx),
    .wrData      (wrData),
    .rdAddrIdx   (rdAddrIdx),
    .rdIndexIdx  (rdIndexIdx),
    .rdOperIdx   (rdOperIdx),
    .memRdata    (memRdata),
    .rdAddrData  (rdAddrData),
    .rdIndexData (rdIndexData),
    .rdOperData  (rdOperData),
    .memAddr     (memAddr),
    .memWdata    (memWdata)
  );
endmodule

// File: tb/opRegUnit_tb.sv
module opRegUnit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrFile = 2'd0;
  logic [2:0]  wrIdx = 3'd0;
  logic [59:0] wrData = '0;
  logic        busy;
  logic [2:0]  rdAddrIdx = 3'd0, rdIndexIdx = 3'd0, rdOperIdx = 3'd0;
  logic [17:0] rdAddrData, rdIndexData;
  logic [59:0] rdOperData;
  logic        memReq, memWe;
  logic [17:0] memAddr;
  logic [59:0] memWdata;
  logic        memAck = 1'b0;
  logic [59:0] memRdata = '0;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  opRegUnit u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrFile(wrFile), .wrIdx(wrIdx),
    .wrData(wrData), .busy(busy), .rdAddrIdx(rdAddrIdx), .rdAddrData(rdAddrData),
    .rdIndexIdx(rdIndexIdx), .rdIndexData(rdIndexData), .rdOperIdx(rdOperIdx),
    .rdOperData(rdOperData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  // {file, idx, data, expected read-back}
  localparam int NV = 7;
  localparam logic [124:0] VEC [NV] = '{
    {2'd1, 3'd1, 60'h00000000003FFFF, 60'h00000000003FFFF},
    {2'd1, 3'd0, 60'h000000000015555, 60'h000000000000000},
    {2'd1, 3'd7, 60'hFFF000000000001, 60'h000000000000001},
    {2'd2, 3'd1, 60'hFFFFFFFFFFFFFFF, 60'hFFFFFFFFFFFFFFF},
    {2'd2, 3'd7, 60'h123456789ABCDEF, 60'h123456789ABCDEF},
    {2'd0, 3'd0, 60'h00000000002AAAA, 60'h00000000002AAAA},
    {2'd2, 3'd6, 60'h0C0FFEE00BADF00, 60'h0C0FFEE00BADF00}
  };

  task automatic chk(input string req, input string what, input logic [59:0] act, input logic [59:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] f, input logic [2:0] i, input logic [59:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrFile = f; wrIdx = i; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ack(input logic [59:0] d);
    memAck = 1'b1; memRdata = d;
    @(negedge clk);
    memAck = 1'b0;
  endtask

  task automatic rdA(input logic [2:0] i, output logic [59:0] v);
    rdAddrIdx = i; #1; v = 60'(rdAddrData);
  endtask
  task automatic rdB(input logic [2:0] i, output logic [59:0] v);
    rdIndexIdx = i; #1; v = 60'(rdIndexData);
  endtask
  task automatic rdX(input logic [2:0] i, output logic [59:0] v);
    rdOperIdx = i; #1; v = rdOperData;
  endtask

  initial begin : watchdog
    #2000000;
    nChecks++; nErrors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin : main
    logic [59:0] v;
    logic [1:0] f;
    logic [2:0] i;
    logic [59:0] d, e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      rdA(3'(r), v); chk("R1", "addr reg after reset", v, '0);
      rdB(3'(r), v); chk("R1", "index reg after reset", v, '0);
      rdX(3'(r), v); chk("R1", "operand reg after reset", v, '0);
    end
    chk("R1", "memReq after reset", 60'(memReq), 60'd0);
    chk("R1", "busy after reset", 60'(busy), 60'd0);

    // vector table: non-memory writes (R2 A0, R8 index, R9 operand)
    for (int n = 0; n < NV; n++) begin
      {f, i, d, e} = VEC[n];
      wr(f, i, d);
      if (f == 2'd0)      begin rdA(i, v); chk("R2", "addr reg readback", v, e); end
      else if (f == 2'd1) begin rdB(i, v); chk("R8", "index reg readback", v, e); end
      else                begin rdX(i, v); chk("R9", "operand reg readback", v, e); end
      chk("R2", "no request after plain write", 60'(memReq), 60'd0);
    end

    // R10 file code 3 ignored
    wr(2'd3, 3'd2, 60'h0000000000ABCDE);
    rdA(3'd2, v); chk("R10", "addr reg2 untouched", v, '0);
    rdB(3'd2, v); chk("R10", "index reg2 untouched", v, '0);
    rdX(3'd2, v); chk("R10", "operand reg2 untouched", v, '0);
    chk("R10", "no request", 60'(memReq), 60'd0);

    // R3/R4 load
    wr(2'd0, 3'd3, 60'h000000000000123);
    chk("R3", "memReq", 60'(memReq), 60'd1);
    chk("R3", "memWe", 60'(memWe), 60'd0);
    chk("R3", "memAddr", 60'(memAddr), 60'h123);
    chk("R3", "busy", 60'(busy), 60'd1);
    rdA(3'd3, v); chk("R3", "addr reg3", v, 60'h123);
    ack(60'h0DEADBEEF012345);
    rdX(3'd3, v); chk("R4", "load data in X3", v, 60'h0DEADBEEF012345);
    chk("R4", "busy after ack", 60'(busy), 60'd0);
    chk("R4", "memReq after ack", 60'(memReq), 60'd0);

    // R9 direct write then load overwrite
    wr(2'd2, 3'd5, 60'h000000000000111);
    rdX(3'd5, v); chk("R9", "direct write X5", v, 60'h111);
    wr(2'd0, 3'd5, 60'h000000000000040);
    ack(60'h555555555555555);
    rdX(3'd5, v); chk("R9", "load overwrites X5", v, 60'h555555555555555);

    // R6 hold without ack
    wr(2'd0, 3'd1, 60'h00000000003ABCD);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6", "memReq held", 60'(memReq), 60'd1);
      chk("R6", "memAddr held", 60'(memAddr), 60'h3ABCD);
      chk("R6", "memWe held", 60'(memWe), 60'd0);
    end
    ack(60'h000000000000001);
    rdX(3'd1, v); chk("R4", "load into X1", v, 60'h1);

    // R5 store with R7 stalls
    wr(2'd0, 3'd6, 60'h000000000002000);
    chk("R5", "memReq", 60'(memReq), 60'd1);
    chk("R5", "memWe", 60'(memWe), 60'd1);
    chk("R5", "memAddr", 60'(memAddr), 60'h2000);
    chk("R5", "memWdata", memWdata, 60'h0C0FFEE00BADF00);
    wrEn = 1'b1; wrFile = 2'd2; wrIdx = 3'd6; wrData = 60'h999999999999999;
    @(negedge clk);
    wrFile = 2'd0; wrIdx = 3'd0; wrData = 60'h000000000001111;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R5", "store data kept", memWdata, 60'h0C0FFEE00BADF00);
    rdX(3'd6, v); chk("R7", "X6 untouched while busy", v, 60'h0C0FFEE00BADF00);
    rdA(3'd0, v); chk("R7", "A0 untouched while busy", v, 60'h2AAAA);
    ack(60'h0);
    chk("R5", "busy after store ack", 60'(busy), 60'd0);
    rdX(3'd6, v); chk("R5", "store leaves X6", v, 60'h0C0FFEE00BADF00);

    // R5 store from register 7
    wr(2'd0, 3'd7, 60'h000000000000001);
    chk("R5", "memWdata X7", memWdata, 60'h123456789ABCDEF);
    chk("R5", "memWe X7", 60'(memWe), 60'd1);
    ack(60'h0);

    // R7/R4 concurrency: load ack with a held index write
    wr(2'd0, 3'd2, 60'h000000000000077);
    wrEn = 1'b1; wrFile = 2'd1; wrIdx = 3'd4; wrData = 60'h000000000000777;
    memAck = 1'b1; memRdata = 60'h0ABCABCABCABCAB;
    @(negedge clk);
    memAck = 1'b0;
    rdX(3'd2, v); chk("R4", "load lands during held write", v, 60'h0ABCABCABCABCAB);
    rdB(3'd4, v); chk("R7", "index4 not written in ack cycle", v, 60'h0);
    chk("R4", "busy low after ack", 60'(busy), 60'd0);
    @(negedge clk);
    wrEn = 1'b0;
    rdB(3'd4, v); chk("R7", "held write taken after busy", v, 60'h777);
    chk("R7", "no request from index write", 60'(memReq), 60'd0);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule